// File: doc/BRIEF.md
# Block address translation unit

This unit turns a 32-bit effective address into a real address for large, naturally aligned memory blocks, without any page-level lookup. Four programmable entries each describe one block. An entry is a pair of 32-bit words. The upper word holds the effective block base, a block-length field and two enable bits, one for supervisor mode and one for user mode. The lower word holds the real block base and a 2-bit protection code.

Software loads the entries through a simple write port. The unit keeps a registered list of the entries that are enabled for the current privilege mode, packed in entry order. It rebuilds this list when an entry word is written and when the privilege mode changes.

A lookup presents an effective address and an access type. One cycle later the unit answers with a response strobe, a hit flag, a protection-fault flag and the translated address. If several active entries cover the address, the lowest-numbered one decides the result. A hit that the protection code forbids gives a fault and no address.

Top module: `bat_xlate_unit`

## Requirements
- R1: After reset every entry word reads as zero, so no entry is active in either mode. A lookup then returns rsp_hit=0, rsp_fault=0 and rsp_ra=0, and rsp_valid stays 0 until a lookup is issued.
- R2: A lookup presented with lk_valid high in cycle t gives rsp_valid high in cycle t+1 only. rsp_hit, rsp_fault and rsp_ra keep their values until the next response.
- R3: A write with cfg_we high targets entry cfg_sel[2:1]. cfg_sel[0]=0 selects the upper word and cfg_sel[0]=1 selects the lower word. Upper-word bit 0 enables the entry in supervisor mode (user_mode=0). Upper-word bit 1 enables it in user mode (user_mode=1).
- R4: The offset mask has upper-word bits [12:2] in mask bits [27:17], ones in mask bits [16:0] and zeros in mask bits [31:28]. An entry matches when (lk_ea AND NOT mask) equals {upper[31:17], 17'b0}.
- R5: On a permitted hit, rsp_ra = (lk_ea AND mask) OR {lower[31:17], 17'b0}.
- R6: When more than one active entry matches, the active entry with the lowest number decides the result.
- R7: lk_acc encodes the access type: 00 is a data read, 01 is a data write, 10 is an instruction fetch, and 11 is treated as a write. The protection code is lower[1:0]. Code 00 denies every access. Code 10 allows every access. Codes 01 and 11 allow reads and fetches and deny writes.
- R8: A denied hit gives rsp_hit=1, rsp_fault=1 and rsp_ra=0. A miss gives rsp_hit=0, rsp_fault=0 and rsp_ra=0.
- R9: A register write or a change of user_mode in cycle t affects lookups issued from cycle t+1 on. A lookup issued in cycle t itself still sees the previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Entry word write strobe |
| cfg_sel | input | 3 | Entry number in [2:1]; 0 selects the upper word and 1 the lower word in [0] |
| cfg_wdata | input | 32 | Word to write |
| user_mode | input | 1 | Current privilege: 1 for user, 0 for supervisor |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address to translate |
| lk_acc | input | 2 | Access type of the lookup |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | An active entry covered the address |
| rsp_fault | output | 1 | Protection violation on the hit |
| rsp_ra | output | 32 | Translated real address, zero unless the access was permitted |

## Verification
Every lookup result is due exactly one clock edge after the cycle in which lk_valid is high. The bench therefore drives a request on a falling edge and compares the response registers on the next falling edge. Configuration writes and mode changes take effect for lookups issued in the following cycle, so the bench lets one falling edge pass after each of them before the next lookup. In one directed case the bench deliberately overlaps a write, and in another a mode change, with a lookup, and expects the old behaviour there. Expected results come from a bench function that walks the entries in order using the rules above.

// File: rtl/bat_xlate_pkg.sv
package bat_xlate_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  // Bit positions inside the upper word that neighbours decode
  localparam int SUP_EN_BIT = 0;
  localparam int USR_EN_BIT = 1;
  localparam int LEN_LSB    = 2;
  localparam int PROT_W     = 2;

  // Protection decision with the key fixed at one
  function automatic logic prot_grants(logic [PROT_W-1:0] prot, logic [1:0] acc);
    logic reads;
    reads = (acc == ACC_READ) || (acc == ACC_FETCH);
    case (prot)
      2'b00:   return 1'b0;
      2'b10:   return 1'b1;
      default: return reads;
    endcase
  endfunction

endpackage

// File: rtl/bat_cfg_regs.sv
module bat_cfg_regs
  import bat_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_ENT  = 4,
  parameter int SEL_W  = $clog2(N_ENT) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] up_d [N_ENT],
  output logic [ADDR_W-1:0] lo_d [N_ENT]
);

  localparam int IDX_W = SEL_W - 1;

  logic [ADDR_W-1:0] up_q [N_ENT];
  logic [ADDR_W-1:0] lo_q [N_ENT];
  logic [N_ENT-1:0]  wr_up;
  logic [N_ENT-1:0]  wr_lo;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    // next-state
    always_comb begin
      wr_up[g] = we && !sel[0] && (sel[SEL_W-1:1] == IDX_W'(g));
      wr_lo[g] = we &&  sel[0] && (sel[SEL_W-1:1] == IDX_W'(g));
      up_d[g]  = wr_up[g] ? wdata : up_q[g];
      lo_d[g]  = wr_lo[g] ? wdata : lo_q[g];
    end

    // registers with explicit enables
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        up_q[g] <= '0;
        lo_q[g] <= '0;
      end else begin
        if (wr_up[g]) up_q[g] <= up_d[g];
        if (wr_lo[g]) lo_q[g] <= lo_d[g];
      end
    end
  end

endmodule

// File: rtl/bat_list_build.sv
module bat_list_build
  import bat_xlate_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int N_ENT    = 4,
  parameter int LEN_W    = 11,
  parameter int PAGE_LSB = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              user_mode,
  input  logic [ADDR_W-1:0] up_d [N_ENT],
  input  logic [ADDR_W-1:0] lo_d [N_ENT],
  output logic [N_ENT-1:0]  slot_vld,
  output logic [ADDR_W-1:0] slot_base  [N_ENT],
  output logic [ADDR_W-1:0] slot_omask [N_ENT],
  output logic [ADDR_W-1:0] slot_rpn   [N_ENT],
  output logic [PROT_W-1:0] slot_prot  [N_ENT]
);

  localparam int IDX_W = $clog2(N_ENT);

  logic [N_ENT-1:0]  ent_act;
  logic [ADDR_W-1:0] ent_base  [N_ENT];
  logic [ADDR_W-1:0] ent_omask [N_ENT];
  logic [ADDR_W-1:0] ent_rpn   [N_ENT];
  logic [PROT_W-1:0] ent_prot  [N_ENT];

  logic [N_ENT-1:0]  nx_vld;
  logic [ADDR_W-1:0] nx_base  [N_ENT];
  logic [ADDR_W-1:0] nx_omask [N_ENT];
  logic [ADDR_W-1:0] nx_rpn   [N_ENT];
  logic [PROT_W-1:0] nx_prot  [N_ENT];
  logic [IDX_W:0]    pos;

  logic mode_q;
  logic rebuild;

  // Field decode of each entry from its next-state words
  for (genvar g = 0; g < N_ENT; g++) begin : g_dec
    logic spare_unused;
    always_comb begin
      ent_act[g]   = user_mode ? up_d[g][USR_EN_BIT] : up_d[g][SUP_EN_BIT];
      ent_omask[g] = ADDR_W'({up_d[g][LEN_LSB+LEN_W-1:LEN_LSB], {PAGE_LSB{1'b1}}});
      ent_base[g]  = {up_d[g][ADDR_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
      ent_rpn[g]   = {lo_d[g][ADDR_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
      ent_prot[g]  = lo_d[g][PROT_W-1:0];
      spare_unused = ^{up_d[g][PAGE_LSB-1:LEN_LSB+LEN_W], lo_d[g][PAGE_LSB-1:PROT_W]};
    end
  end

  // Pack the active entries, keeping entry order
  always_comb begin
    nx_vld = '0;
    for (int i = 0; i < N_ENT; i++) begin
      nx_base[i]  = '0;
      nx_omask[i] = '0;
      nx_rpn[i]   = '0;
      nx_prot[i]  = '0;
    end
    pos = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (ent_act[i]) begin
        nx_vld[pos[IDX_W-1:0]]   = 1'b1;
        nx_base[pos[IDX_W-1:0]]  = ent_base[i];
        nx_omask[pos[IDX_W-1:0]] = ent_omask[i];
        nx_rpn[pos[IDX_W-1:0]]   = ent_rpn[i];
        nx_prot[pos[IDX_W-1:0]]  = ent_prot[i];
        pos = pos + (IDX_W+1)'(1);
      end
    end
  end

  assign rebuild = cfg_we || (user_mode != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      slot_vld <= '0;
    end else begin
      mode_q <= user_mode;
      if (rebuild) slot_vld <= nx_vld;
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_base[g]  <= '0;
        slot_omask[g] <= '0;
        slot_rpn[g]   <= '0;
        slot_prot[g]  <= '0;
      end else if (rebuild) begin
        slot_base[g]  <= nx_base[g];
        slot_omask[g] <= nx_omask[g];
        slot_rpn[g]   <= nx_rpn[g];
        slot_prot[g]  <= nx_prot[g];
      end
    end
  end

endmodule

// File: rtl/bat_match.sv
module bat_match
  import bat_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_ENT  = 4
) (
  input  logic [ADDR_W-1:0] ea,
  input  logic [1:0]        acc,
  input  logic [N_ENT-1:0]  slot_vld,
  input  logic [ADDR_W-1:0] slot_base  [N_ENT],
  input  logic [ADDR_W-1:0] slot_omask [N_ENT],
  input  logic [ADDR_W-1:0] slot_rpn   [N_ENT],
  input  logic [PROT_W-1:0] slot_prot  [N_ENT],
  output logic              hit,
  output logic              fault,
  output logic [ADDR_W-1:0] ra
);

  logic              found;
  logic              grant;
  logic [ADDR_W-1:0] sel_ra;
  logic [PROT_W-1:0] sel_prot;

  // First slot in list order that covers the address wins
  always_comb begin
    found    = 1'b0;
    sel_ra   = '0;
    sel_prot = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (!found && slot_vld[i] && ((ea & ~slot_omask[i]) == slot_base[i])) begin
        found    = 1'b1;
        sel_ra   = (ea & slot_omask[i]) | slot_rpn[i];
        sel_prot = slot_prot[i];
      end
    end
    grant = prot_grants(sel_prot, acc);
    hit   = found;
    fault = found && !grant;
    ra    = (found && grant) ? sel_ra : '0;
  end

endmodule

// File: rtl/bat_xlate_unit.sv
module bat_xlate_unit
  import bat_xlate_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int N_ENT    = 4,
  parameter int LEN_W    = 11,
  parameter int PAGE_LSB = 17,
  localparam int IDX_W   = $clog2(N_ENT),
  localparam int SEL_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              user_mode,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_ea,
  input  logic [1:0]        lk_acc,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_ra
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  logic [ADDR_W-1:0] up_d [N_ENT];
  logic [ADDR_W-1:0] lo_d [N_ENT];
  logic [N_ENT-1:0]  slot_vld;
  logic [ADDR_W-1:0] slot_base  [N_ENT];
  logic [ADDR_W-1:0] slot_omask [N_ENT];
  logic [ADDR_W-1:0] slot_rpn   [N_ENT];
  logic [PROT_W-1:0] slot_prot  [N_ENT];
  logic              m_hit;
  logic              m_fault;
  logic [ADDR_W-1:0] m_ra;

  bat_cfg_regs #(.ADDR_W(ADDR_W), .N_ENT(N_ENT), .SEL_W(SEL_W)) regs_i (
    .clk   (clk),
    .rst_n (rst_sn),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .up_d  (up_d),
    .lo_d  (lo_d)
  );

  bat_list_build #(.ADDR_W(ADDR_W), .N_ENT(N_ENT), .LEN_W(LEN_W), .PAGE_LSB(PAGE_LSB)) list_i (
    .clk        (clk),
    .rst_n      (rst_sn),
    .cfg_we     (cfg_we),
    .user_mode  (user_mode),
    .up_d       (up_d),
    .lo_d       (lo_d),
    .slot_vld   (slot_vld),
    .slot_base  (slot_base),
    .slot_omask (slot_omask),
    .slot_rpn   (slot_rpn),
    .slot_prot  (slot_prot)
  );

  bat_match #(.ADDR_W(ADDR_W), .N_ENT(N_ENT)) match_i (
    .ea         (lk_ea),
    .acc        (lk_acc),
    .slot_vld   (slot_vld),
    .slot_base  (slot_base),
    .slot_omask (slot_omask),
    .slot_rpn   (slot_rpn),
    .slot_prot  (slot_prot),
    .hit        (m_hit),
    .fault      (m_fault),
    .ra         (m_ra)
  );

  // Response stage
  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_hit_q,   rsp_hit_d;
  logic              rsp_fault_q, rsp_fault_d;
  logic [ADDR_W-1:0] rsp_ra_q,    rsp_ra_d;

  always_comb begin
    rsp_valid_d = lk_valid;
    rsp_hit_d   = rsp_hit_q;
    rsp_fault_d = rsp_fault_q;
    rsp_ra_d    = rsp_ra_q;
    if (lk_valid) begin
      rsp_hit_d   = m_hit;
      rsp_fault_d = m_fault;
      rsp_ra_d    = m_ra;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_ra_q    <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      rsp_fault_q <= rsp_fault_d;
      rsp_ra_q    <= rsp_ra_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_fault = rsp_fault_q;
  assign rsp_ra    = rsp_ra_q;

endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic [ADDR_W-1:0] lk_ea,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_fault,
  input logic [ADDR_W-1:0] rsp_ra
);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);  // R2

  AST_RSP_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);  // R2

  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_hit);  // R8

  AST_NO_ADDR_UNGRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault || !rsp_hit)) |-> (rsp_ra == '0));  // R8

  AST_OFFSET_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit && !rsp_fault) |->
      (rsp_ra[PAGE_LSB-1:0] == $past(lk_ea[PAGE_LSB-1:0])));  // R5

endmodule

bind bat_xlate_unit bat_xlate_chk #(.ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sn),
  .lk_valid  (lk_valid),
  .lk_ea     (lk_ea),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_fault (rsp_fault),
  .rsp_ra    (rsp_ra)
);

// File: tb/bat_xlate_unit_tb_top.sv
module bat_xlate_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 32'h5EED_0BA7;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        user_mode;
  logic        lk_valid;
  logic [31:0] lk_ea;
  logic [1:0]  lk_acc;
  logic        rsp_valid;
  logic        rsp_hit;
  logic        rsp_fault;
  logic [31:0] rsp_ra;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] m_up [4];
  logic [31:0] m_lo [4];
  logic        m_user;

  bat_xlate_unit dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .user_mode (user_mode),
    .lk_valid  (lk_valid),
    .lk_ea     (lk_ea),
    .lk_acc    (lk_acc),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_fault (rsp_fault),
    .rsp_ra    (rsp_ra)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] f_omask(logic [31:0] up);
    return {4'b0, up[12:2], 17'h1FFFF};
  endfunction

  // Expected {hit, fault, ra} from the requirements
  function automatic logic [33:0] model(logic [31:0] ea, logic [1:0] acc);
    logic        hit, fault, ok;
    logic [31:0] ra, om;
    logic [1:0]  pp;
    hit = 1'b0; ra = '0; pp = '0;
    for (int i = 0; i < 4; i++) begin
      om = f_omask(m_up[i]);
      if (!hit && (m_user ? m_up[i][1] : m_up[i][0]) &&
          ((ea & ~om) == {m_up[i][31:17], 17'b0})) begin
        hit = 1'b1;
        pp  = m_lo[i][1:0];
        ra  = (ea & om) | {m_lo[i][31:17], 17'b0};
      end
    end
    if (pp == 2'b10)      ok = 1'b1;
    else if (pp == 2'b00) ok = 1'b0;
    else                  ok = (acc == 2'b00) || (acc == 2'b10);
    fault = hit && !ok;
    if (!hit || fault) ra = '0;
    return {hit, fault, ra};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int ent, input bit lower, input logic [31:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_sel   = {ent[1:0], lower};
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (lower) m_lo[ent] = d;
    else       m_up[ent] = d;
  endtask

  task automatic set_mode(input bit u);
    @(negedge clk);
    user_mode = u;
    @(negedge clk);
    m_user = u;
  endtask

  task automatic lookup_chk(input string tag, input logic [31:0] ea, input logic [1:0] acc);
    logic [33:0] exp;
    exp = model(ea, acc);
    @(negedge clk);
    lk_valid = 1'b1; lk_ea = ea; lk_acc = acc;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(tag, 64'({rsp_valid, rsp_hit, rsp_fault, rsp_ra}), 64'({1'b1, exp}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [33:0] old_exp;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    user_mode = 1'b0; lk_valid = 1'b0; lk_ea = '0; lk_acc = '0;
    m_user = 1'b0;
    for (int i = 0; i < 4; i++) begin m_up[i] = '0; m_lo[i] = '0; end
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 idle strobe", 64'(rsp_valid), 64'(0));
    lookup_chk("R1 miss after reset", 32'h1234_5678, 2'b00);
    set_mode(1'b1);
    lookup_chk("R1 miss after reset user", 32'h0000_0000, 2'b10);
    set_mode(1'b0);

    // R2: single-cycle strobe, outputs hold
    @(negedge clk);
    chk("R2 strobe drops", 64'(rsp_valid), 64'(0));

    // R3 R4 R5: basic block, supervisor only
    cfg_write(0, 0, 32'h1000_0001);
    cfg_write(0, 1, 32'h8000_0002);
    lookup_chk("R4 R5 basic hit", 32'h1001_2345, 2'b00);
    lookup_chk("R4 outside block", 32'h1002_0000, 2'b00);
    set_mode(1'b1);
    lookup_chk("R3 user not enabled", 32'h1001_2345, 2'b00);
    cfg_write(0, 0, 32'h1000_0002);
    lookup_chk("R3 user enabled", 32'h1001_2345, 2'b01);
    set_mode(1'b0);
    lookup_chk("R3 supervisor disabled", 32'h1001_2345, 2'b00);

    // R4 R5 R7: longer block, read-only code 01
    cfg_write(1, 0, 32'h2000_000D);
    cfg_write(1, 1, 32'h4000_0001);
    lookup_chk("R5 longer block read", 32'h2006_5432, 2'b00);
    lookup_chk("R7 code01 write denied", 32'h2006_5432, 2'b01);
    lookup_chk("R7 reserved access as write", 32'h2006_5432, 2'b11);
    lookup_chk("R7 code01 fetch ok", 32'h2001_0000, 2'b10);
    lookup_chk("R4 past block length", 32'h2008_0000, 2'b00);

    // R6: overlapping entries, lowest active wins
    cfg_write(2, 0, 32'h3000_0001);
    cfg_write(2, 1, 32'h5000_0000);
    cfg_write(3, 0, 32'h3000_0003);
    cfg_write(3, 1, 32'h6000_0003);
    lookup_chk("R6 lower entry wins", 32'h3000_0100, 2'b00);
    lookup_chk("R7 R8 code00 fetch fault", 32'h3000_0100, 2'b10);
    set_mode(1'b1);
    lookup_chk("R6 only higher active in user", 32'h3000_0100, 2'b10);
    lookup_chk("R7 code11 write denied", 32'h3000_0100, 2'b01);
    set_mode(1'b0);
    cfg_write(2, 0, 32'h3000_0000);
    lookup_chk("R6 next active entry", 32'h3000_0100, 2'b00);

    // R9: write overlapping a lookup sees old configuration
    old_exp = model(32'h3000_0100, 2'b00);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = {2'd3, 1'b1}; cfg_wdata = 32'h7000_0002;
    lk_valid = 1'b1; lk_ea = 32'h3000_0100; lk_acc = 2'b00;
    @(negedge clk);
    cfg_we = 1'b0; lk_valid = 1'b0; m_lo[3] = 32'h7000_0002;
    chk("R9 concurrent write old", 64'({rsp_valid, rsp_hit, rsp_fault, rsp_ra}), 64'({1'b1, old_exp}));
    lookup_chk("R9 next cycle new", 32'h3000_0100, 2'b00);

    // R9: mode change overlapping a lookup
    old_exp = model(32'h1001_0000, 2'b00);
    @(negedge clk);
    user_mode = 1'b1;
    lk_valid = 1'b1; lk_ea = 32'h1001_0000; lk_acc = 2'b00;
    @(negedge clk);
    lk_valid = 1'b0; m_user = 1'b1;
    chk("R9 concurrent mode old", 64'({rsp_valid, rsp_hit, rsp_fault, rsp_ra}), 64'({1'b1, old_exp}));
    lookup_chk("R9 R3 mode new", 32'h1001_0000, 2'b00);

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int r;
      r = int'($urandom % 10);
      if (r == 0) begin
        int e;
        logic [31:0] d;
        e = int'($urandom % 4);
        d = $urandom;
        if ($urandom % 2 == 0) begin
          if ($urandom % 2 == 0) d = (d & ~f_omask(d)) | (d & 32'h0000_1FFF);
          cfg_write(e, 0, d);
        end else begin
          cfg_write(e, 1, d);
        end
      end else if (r == 1) begin
        set_mode(!m_user);
      end else begin
        int k;
        logic [31:0] ea;
        k  = int'($urandom % 4);
        ea = ($urandom % 4 == 0) ? $urandom
             : ({m_up[k][31:17], 17'b0} | ($urandom & f_omask(m_up[k])));
        lookup_chk("R4 R5 R6 R7 R8 random", ea, 2'($urandom));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule